// File: doc/BRIEF.md
# Nine-Bit Serial Command Link Master

This block is the controller side of a three-wire control link to a display panel. Every word on the link is nine bits long. The top bit tells the panel whether the remaining eight bits are a command (bit clear) or data (bit set). A write request carries one command byte and a count of parameter bytes. The block sends the command word and then one parameter word per byte. It fetches each byte from the requester only when it is about to send it, using a one-cycle strobe.

A second kind of request reads the panel's one-byte identifier, in three steps. The block first sends the fixed query command. It then clocks a nine-bit receive word, made of one extra clock plus a dummy byte, and throws it away. Finally it clocks an eight-bit receive word that holds the identifier.

The serial clock is derived from the system clock by a half-period divider. The link runs in mode 0. Chip select drops for each single word and rises again after it. Consecutive words are separated by a chip-select-high gap of at least one serial period.

Top module: `ctl9_link_master`

## Requirements
- R1: A write transaction's first frame is nine bits, with bit 8 = 0 and bits 7..0 equal to the requested command byte. Bits are shifted out MSB first on `mosi`.
- R2: After the command frame come exactly `wr_count` parameter frames, each nine bits: bit 8 = 1 and bits 7..0 the fetched byte. Bytes are sent in fetch order. `prm_req` pulses once per parameter frame, and `prm_byte` is taken in the same cycle.
- R3: A write with `wr_count` = 0 produces the command frame only, with no `prm_req` pulse.
- R4: `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low, so it changes on falling edges and is stable across every rising edge.
- R5: Each `sclk` high phase lasts HALF_DIV system cycles. Each low phase inside a frame, including the one from the fall of `cs_n` to the first rising edge, also lasts HALF_DIV cycles.
- R6: `cs_n` goes high after every single word. Between two words of one transaction it stays high for exactly 2*HALF_DIV+1 system cycles.
- R7: An identifier read produces three frames, all with `mosi` low except the first. The first frame is nine bits with value 0x004. The second is nine receive bits, which are discarded. The third is eight receive bits. `id_data` takes the eight `miso` bits of the third frame, MSB first, sampled on rising `sclk` edges.
- R8: `req_ready` is high only while idle. A request is accepted in a cycle where its valid and `req_ready` are both high. If `wr_valid` and `id_valid` are both high, the write is taken and the read is not started.
- R9: `done` is a single-cycle pulse at the end of every transaction. `id_data` changes only at the end of an identifier read, and write transactions leave it unchanged.
- R10: During and after reset, before any request, `cs_n` = 1, `sclk` = 0, `mosi` = 0, `req_ready` = 1, `done` = 0 and `id_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_ready | output | 1 | Idle; a request may be accepted |
| wr_valid | input | 1 | Write request present |
| wr_cmd | input | 8 | Command byte of the write request |
| wr_count | input | CNT_W | Number of parameter bytes to send |
| id_valid | input | 1 | Identifier read request present |
| prm_req | output | 1 | Strobe: parameter byte consumed this cycle |
| prm_byte | input | 8 | Next parameter byte, valid while `prm_req` is high |
| done | output | 1 | Transaction finished (one-cycle pulse) |
| id_data | output | 8 | Last identifier read |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to panel |
| miso | input | 1 | Serial data from panel |

## Verification
The bench builds the block with HALF_DIV = 2 and CNT_W = 3. With these values every parameter count from zero to the maximum of seven can be swept for several command bytes, and each serial phase and chip-select gap is only a few cycles long, so it can be measured exactly against the formula. Identifier reads are swept over edge values and a spread of codes, and the dummy word alternates between all ones and a mixed pattern to show it has no effect on the result.

// File: rtl/ctl9_link_pkg.sv
package ctl9_link_pkg;
   localparam int unsigned WORD_BITS = 9;
   localparam int unsigned BYTE_BITS = 8;

   typedef logic [WORD_BITS-1:0] word9_t;
   typedef logic [BYTE_BITS-1:0] byte_t;

   // Fixed query command word for the identifier read (bit 8 clear = command)
   localparam word9_t ID_QUERY = 9'h004;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CMD,
      SQ_PARM,
      SQ_RCMD,
      SQ_RDUM,
      SQ_RDAT
   } seq_e;
endpackage

// File: rtl/ctl9_halfper.sv
module ctl9_halfper #(
   parameter int unsigned HALF_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!en)          cnt <= '0;
      else if (cnt == LAST)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);
endmodule

// File: rtl/ctl9_shifter.sv
module ctl9_shifter
   import ctl9_link_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  word9_t     tx_word,
   input  logic [3:0] nbits,
   input  logic       tick,
   input  logic       miso,
   output logic       busy,
   output logic       cs_n,
   output logic       sclk,
   output logic       mosi,
   output byte_t      rx_byte,
   output logic       word_done
);
   localparam int unsigned HW = 5;

   word9_t        sh;
   logic [HW-1:0] halves;
   logic [3:0]    nb;
   logic [HW-1:0] edge_end;
   logic [HW-1:0] gap_end;

   assign edge_end = {nb, 1'b0};
   assign gap_end  = edge_end + 5'd2;
   assign mosi     = sh[WORD_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cs_n      <= 1'b1;
         sclk      <= 1'b0;
         sh        <= '0;
         rx_byte   <= '0;
         halves    <= '0;
         nb        <= '0;
         word_done <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            cs_n    <= 1'b0;
            sclk    <= 1'b0;
            sh      <= tx_word;
            rx_byte <= '0;
            halves  <= '0;
            nb      <= nbits;
         end else if (busy && tick) begin
            halves <= halves + 5'd1;
            if (halves < edge_end) begin
               if (!halves[0]) begin
                  sclk    <= 1'b1;
                  rx_byte <= {rx_byte[BYTE_BITS-2:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (halves + 5'd1 == edge_end) begin
                     cs_n <= 1'b1;
                     sh   <= '0;
                  end else begin
                     sh <= {sh[WORD_BITS-2:0], 1'b0};
                  end
               end
            end else if (halves + 5'd1 == gap_end) begin
               busy      <= 1'b0;
               word_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ctl9_link_master.sv
module ctl9_link_master
   import ctl9_link_pkg::*;
#(
   parameter int unsigned HALF_DIV = 50,
   parameter int unsigned CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             req_ready,
   input  logic             wr_valid,
   input  logic [7:0]       wr_cmd,
   input  logic [CNT_W-1:0] wr_count,
   input  logic             id_valid,
   output logic             prm_req,
   input  logic [7:0]       prm_byte,
   output logic             done,
   output logic [7:0]       id_data,
   output logic             cs_n,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso
);
   localparam logic [3:0] NB_WORD = 4'(WORD_BITS);
   localparam logic [3:0] NB_BYTE = 4'(BYTE_BITS);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("ctl9_link_master: HALF_DIV must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("ctl9_link_master: CNT_W must lie in 1..16");
      end
   endgenerate

   seq_e             st;
   logic [CNT_W-1:0] left;
   logic             sh_start;
   word9_t           sh_tx;
   logic [3:0]       sh_nb;
   logic             sh_busy;
   logic             tick;
   byte_t            rx_byte;
   logic             word_done;

   ctl9_halfper #(.HALF_DIV(HALF_DIV)) div_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (sh_busy),
      .tick (tick)
   );

   ctl9_shifter shf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sh_start),
      .tx_word  (sh_tx),
      .nbits    (sh_nb),
      .tick     (tick),
      .miso     (miso),
      .busy     (sh_busy),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .mosi     (mosi),
      .rx_byte  (rx_byte),
      .word_done(word_done)
   );

   assign req_ready = (st == SQ_IDLE);

   always_comb begin
      sh_start = 1'b0;
      sh_tx    = '0;
      sh_nb    = NB_WORD;
      prm_req  = 1'b0;
      unique case (st)
         SQ_IDLE: begin
            if (wr_valid) begin
               sh_start = 1'b1;
               sh_tx    = {1'b0, wr_cmd};
            end else if (id_valid) begin
               sh_start = 1'b1;
               sh_tx    = ID_QUERY;
            end
         end
         SQ_CMD, SQ_PARM: begin
            if (word_done && left != '0) begin
               prm_req  = 1'b1;
               sh_start = 1'b1;
               sh_tx    = {1'b1, prm_byte};
            end
         end
         SQ_RCMD: sh_start = word_done;
         SQ_RDUM: begin
            sh_start = word_done;
            sh_nb    = NB_BYTE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         left    <= '0;
         done    <= 1'b0;
         id_data <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (wr_valid) begin
                  st   <= SQ_CMD;
                  left <= wr_count;
               end else if (id_valid) begin
                  st <= SQ_RCMD;
               end
            end
            SQ_CMD, SQ_PARM: begin
               if (word_done) begin
                  if (left != '0) begin
                     left <= left - 1'b1;
                     st   <= SQ_PARM;
                  end else begin
                     st   <= SQ_IDLE;
                     done <= 1'b1;
                  end
               end
            end
            SQ_RCMD: if (word_done) st <= SQ_RDUM;
            SQ_RDUM: if (word_done) st <= SQ_RDAT;
            SQ_RDAT: begin
               if (word_done) begin
                  id_data <= rx_byte;
                  done    <= 1'b1;
                  st      <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ctl9_link_master_chk.sv
module ctl9_link_master_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic wr_valid,
   input logic id_valid,
   input logic prm_req,
   input logic done,
   input logic cs_n,
   input logic sclk,
   input logic mosi
);
   assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_mosi_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi) |-> !sclk);

   assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);

   assert_prm_between_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prm_req |-> cs_n);

   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && (wr_valid || id_valid)) |=> !req_ready);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind ctl9_link_master ctl9_link_master_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .wr_valid (wr_valid),
   .id_valid (id_valid),
   .prm_req  (prm_req),
   .done     (done),
   .cs_n     (cs_n),
   .sclk     (sclk),
   .mosi     (mosi)
);

// File: tb/ctl9_link_master_tb_top.sv
module ctl9_link_master_tb_top;
   localparam int H     = 2;
   localparam int CNT_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_ready, wr_valid = 1'b0, id_valid = 1'b0;
   logic [7:0] wr_cmd = '0;
   logic [CNT_W-1:0] wr_count = '0;
   logic prm_req, done;
   logic [7:0] prm_byte, id_data;
   logic cs_n, sclk, mosi;
   logic miso = 1'b0;

   int tests = 0, fails = 0, cycles = 0;

   always #5 clk = ~clk;

   ctl9_link_master #(.HALF_DIV(H), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
      .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_count(wr_count),
      .id_valid(id_valid), .prm_req(prm_req), .prm_byte(prm_byte),
      .done(done), .id_data(id_data), .cs_n(cs_n), .sclk(sclk),
      .mosi(mosi), .miso(miso)
   );

   function automatic logic [7:0] byte_fn(input logic [7:0] c, input int i);
      return 8'(int'(c) * 29 + i * 53 + 90);
   endfunction

   // parameter byte source
   logic [7:0] cur_cmd = '0;
   int prm_seen = 0;
   assign prm_byte = byte_fn(cur_cmd, prm_seen);
   always @(posedge clk) if (prm_req) prm_seen <= prm_seen + 1;

   // panel model: frame capture and response
   logic [8:0] fr_val [0:15];
   int         fr_len [0:15];
   int nfr = 0, cur_len = 0, bit_i = 0;
   logic [8:0] cur_val = '0;
   logic [8:0] rsp [0:2];

   always @(negedge cs_n) begin
      cur_len = 0; cur_val = '0; bit_i = 0;
      miso = (nfr < 3) ? rsp[nfr][8] : 1'b0;
   end
   always @(posedge sclk) if (!cs_n) begin
      cur_val = {cur_val[7:0], mosi};
      cur_len++;
   end
   always @(negedge sclk) if (!cs_n) begin
      bit_i++;
      if (bit_i <= 8 && nfr < 3) miso = rsp[nfr][8-bit_i];
   end
   always @(posedge cs_n) if (nfr < 16) begin
      fr_val[nfr] = cur_val;
      fr_len[nfr] = cur_len;
      nfr++;
   end

   // timing monitor, sampled mid-cycle
   int err_r4 = 0, err_r5 = 0, err_r6 = 0, err_r9 = 0;
   int hi_run = 0, lo_run = 0, cs_run = 0, done_run = 0;
   logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
   always @(negedge clk) if (rst_n) begin
      if (cs_n && sclk) err_r4++;
      if (mosi !== p_mosi && sclk) err_r4++;
      if (sclk && !p_sclk) begin
         if (lo_run != H) err_r5++;
         lo_run = 0;
      end
      if (!sclk && p_sclk) begin
         if (hi_run != H) err_r5++;
         hi_run = 0;
      end
      if (sclk) hi_run++;
      if (!sclk && !cs_n) lo_run++;
      if (cs_n) lo_run = 0;
      if (!cs_n && p_cs) begin
         if (nfr > 0 && cs_run != 2*H+1) err_r6++;
         cs_run = 0;
      end
      if (cs_n) cs_run++;
      if (done) done_run++; else done_run = 0;
      if (done_run > 1) err_r9++;
      p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         finish_run();
      end
   end

   task automatic run_txn(input bit do_wr, input bit do_id, input logic [7:0] c, input int cnt);
      nfr = 0; prm_seen = 0; cur_cmd = c;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      wr_valid = do_wr; id_valid = do_id; wr_cmd = c; wr_count = CNT_W'(cnt);
      @(negedge clk);
      wr_valid = 1'b0; id_valid = 1'b0;
      check("R8 busy after accept", 32'(req_ready), 32'd0);
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_write(input logic [7:0] c, input int cnt);
      int bad = 0;
      check("R2/R3 frame count", nfr, cnt + 1);
      check("R1 command frame", {fr_len[0][3:0], 7'd0, fr_val[0]}, {4'd9, 7'd0, 1'b0, c});
      for (int i = 1; i <= cnt && i < 16; i++)
         if (fr_len[i] != 9 || fr_val[i] !== {1'b1, byte_fn(c, i-1)}) bad++;
      check("R2 parameter frames", bad, 0);
      check(cnt == 0 ? "R3 no parameter fetch" : "R2 fetch count", prm_seen, cnt);
   endtask

   initial begin
      rsp[0] = '0; rsp[1] = '0; rsp[2] = '0;
      repeat (3) @(negedge clk);
      check("R10 reset cs_n", 32'(cs_n), 1);
      check("R10 reset sclk/mosi", {sclk, mosi}, 0);
      check("R10 reset ready/done", {req_ready, done}, 2'b10);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 idle id_data", id_data, 0);
      check("R10 idle lines", {cs_n, sclk, mosi, req_ready, done}, 5'b10010);

      // write sweep: every parameter count for several command bytes
      for (int k = 0; k < 3; k++) begin
         logic [7:0] c;
         c = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h36;
         for (int n = 0; n < 8; n++) begin
            run_txn(1'b1, 1'b0, c, n);
            check_write(c, n);
         end
      end
      check("R9 write keeps id_data", id_data, 0);

      // identifier read sweep
      for (int i = 0; i < 10; i++) begin
         logic [7:0] idv;
         idv = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h80 : 8'(i * 37 + 1);
         rsp[0] = 9'h1FF;
         rsp[1] = (i % 2 == 0) ? 9'h1FF : 9'h0AA;
         rsp[2] = {idv, 1'b0};
         run_txn(1'b0, 1'b1, 8'h00, 0);
         check("R7 frame count", nfr, 3);
         check("R7 query frame", {fr_len[0][3:0], 7'd0, fr_val[0]}, {4'd9, 7'd0, 9'h004});
         check("R7 receive frames", {fr_len[1][3:0], fr_len[2][3:0], fr_val[1], fr_val[2]},
               {4'd9, 4'd8, 9'd0, 9'd0});
         check("R7 identifier", id_data, idv);
      end

      // both requests at once: write wins, id_data untouched
      run_txn(1'b1, 1'b1, 8'hA5, 2);
      check("R8 write priority", nfr, 3);
      check_write(8'hA5, 2);
      check("R9 id_data after write", id_data, 8'(9 * 37 + 1));
      repeat (10) @(negedge clk);
      check("R8 read not started", {nfr, 31'd0} == '0 ? 0 : 32'(nfr), 3);

      check("R4 mode 0 edges", err_r4, 0);
      check("R5 half period", err_r5, 0);
      check("R6 chip select gap", err_r6, 0);
      check("R9 done width", err_r9, 0);
      finish_run();
   end
endmodule